// File: doc/BRIEF.md
# Two-Destination Predicate Define Unit

This block is the execute-stage datapath for a compare instruction whose results land in a one-bit predicate register file. It compares two integer operands under a selected relation to form a condition bit. For each of two destination predicates, it then combines that condition with the instruction's guard predicate under a per-destination deposit kind. The result for each destination is a write enable, a write value, the destination index, and two flags. The flags tell the commit logic whether the write may be merged with other writes to the same register in the same cycle as a wired-OR or as a wired-AND. Reading the operands and committing to the register file happen outside the block.

Operations enter on a valid/ready stream and leave on another. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. It is consumed on an edge where `out_valid` and `out_ready` are both high. The parameter `OUT_REG` chooses the output path. With it set to 0, the path is purely combinational and ready passes straight back. With it set to 1 (the default), there is one register stage. That stage accepts a new operation whenever it is empty or its contents are leaving in the same cycle, and it holds its output unchanged while the consumer stalls.

Top module: `pred_define_unit`

## Requirements
- R1: The condition is src0 against src1 under `rel`: 0 equal, 1 not equal, 2 signed less, 3 signed less-or-equal, 4 signed greater, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned less-or-equal, 8 unsigned greater; codes 9 to 15 give a condition of 0.
- R2: Kinds 0 and 1 always write; kind 0 writes guard AND condition, kind 1 writes guard AND NOT condition.
- R3: Kind 2 writes 1 when guard and condition are both 1; kind 3 writes 1 when guard is 1 and condition is 0; otherwise no write.
- R4: Kind 4 writes 0 when guard is 1 and condition is 0; kind 5 writes 0 when guard and condition are both 1; otherwise no write.
- R5: With guard 1, kind 6 writes the condition and kind 7 writes its inverse; with guard 0 neither writes.
- R6: Kind 8 writes 1 when guard or condition is 1; kind 9 writes 1 when guard is 1 or condition is 0; otherwise no write.
- R7: Kind 10 writes 0 when guard or condition is 0; kind 11 writes 0 when guard is 0 or condition is 1; otherwise no write.
- R8: Kinds 12 to 15 never write; whenever a write enable is low its value and merge flags are 0.
- R9: Each destination follows its own kind and index, and both share one condition and one guard.
- R10: The wired-OR flag is set exactly on writes of kinds 2, 3, 8 and 9. The wired-AND flag is set exactly on writes of kinds 4, 5, 10 and 11. The two flags are never set together.
- R11: A destination with index 0 is never written.
- R12: Results leave in the order accepted. With `OUT_REG`=1, `out_valid` is low after reset and `in_ready` equals NOT `out_valid` OR `out_ready`. A stalled output (valid high, ready low) holds all fields unchanged until consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| src0 | input | DW | First operand |
| src1 | input | DW | Second operand |
| rel | input | 4 | Comparison relation code |
| guard | input | 1 | Guard predicate value |
| kind0 | input | 4 | Deposit kind, destination 0 |
| dst0 | input | IW | Register index, destination 0 |
| kind1 | input | 4 | Deposit kind, destination 1 |
| dst1 | input | IW | Register index, destination 1 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| wr0_en | output | 1 | Write enable, destination 0 |
| wr0_val | output | 1 | Write value, destination 0 |
| wr0_mor | output | 1 | Wired-OR mergeable, destination 0 |
| wr0_mand | output | 1 | Wired-AND mergeable, destination 0 |
| wr0_idx | output | IW | Register index, destination 0 |
| wr1_en | output | 1 | Write enable, destination 1 |
| wr1_val | output | 1 | Write value, destination 1 |
| wr1_mor | output | 1 | Wired-OR mergeable, destination 1 |
| wr1_mand | output | 1 | Wired-AND mergeable, destination 1 |
| wr1_idx | output | IW | Register index, destination 1 |

## Verification
The hold property assumes the upstream side obeys the stream rules: once an operation is offered, it stays stable until accepted. The bench's driver keeps `in_valid` and every operand field fixed until it sees `in_ready`, and only then changes them. The merge-flag and index properties assume nothing about the inputs, so the bench feeds every kind code (legal and not), every guard and condition pairing, and index 0. The consumer's ready follows a pseudo-random pattern, so that stalls of one and of several cycles both occur.

// File: rtl/pdu_pkg.sv
package pdu_pkg;
  // comparison relations
  localparam logic [3:0] REL_EQ  = 4'd0;
  localparam logic [3:0] REL_NE  = 4'd1;
  localparam logic [3:0] REL_LT  = 4'd2;
  localparam logic [3:0] REL_LE  = 4'd3;
  localparam logic [3:0] REL_GT  = 4'd4;
  localparam logic [3:0] REL_GE  = 4'd5;
  localparam logic [3:0] REL_LTU = 4'd6;
  localparam logic [3:0] REL_LEU = 4'd7;
  localparam logic [3:0] REL_GTU = 4'd8;

  // deposit kinds
  localparam logic [3:0] K_UNC_T  = 4'd0;
  localparam logic [3:0] K_UNC_F  = 4'd1;
  localparam logic [3:0] K_OR_T   = 4'd2;
  localparam logic [3:0] K_OR_F   = 4'd3;
  localparam logic [3:0] K_AND_T  = 4'd4;
  localparam logic [3:0] K_AND_F  = 4'd5;
  localparam logic [3:0] K_CND_T  = 4'd6;
  localparam logic [3:0] K_CND_F  = 4'd7;
  localparam logic [3:0] K_DIS_T  = 4'd8;
  localparam logic [3:0] K_DIS_F  = 4'd9;
  localparam logic [3:0] K_CON_T  = 4'd10;
  localparam logic [3:0] K_CON_F  = 4'd11;

  typedef struct packed {
    logic en;
    logic val;
    logic m_or;
    logic m_and;
  } pwr_t;

  localparam int PWR_W = $bits(pwr_t);
endpackage

// File: rtl/pdu_cmp.sv
module pdu_cmp #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    rel,
  output logic          cond
);
  import pdu_pkg::*;

  logic eq, slt, ult;

  always_comb begin
    eq  = (a == b);
    slt = ($signed(a) < $signed(b));
    ult = (a < b);
    unique case (rel)
      REL_EQ:  cond = eq;
      REL_NE:  cond = !eq;
      REL_LT:  cond = slt;
      REL_LE:  cond = slt || eq;
      REL_GT:  cond = !(slt || eq);
      REL_GE:  cond = !slt;
      REL_LTU: cond = ult;
      REL_LEU: cond = ult || eq;
      REL_GTU: cond = !(ult || eq);
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/pdu_deposit.sv
module pdu_deposit #(
  parameter int IW = 6
) (
  input  logic          guard,
  input  logic          cond,
  input  logic [3:0]    kind,
  input  logic [IW-1:0] idx,
  output pdu_pkg::pwr_t wr
);
  import pdu_pkg::*;

  logic en_raw, val_raw, mor_raw, mand_raw;
  logic gc, gnc;

  always_comb begin
    gc  = guard && cond;
    gnc = guard && !cond;
    en_raw   = 1'b0;
    val_raw  = 1'b0;
    mor_raw  = 1'b0;
    mand_raw = 1'b0;
    unique case (kind)
      K_UNC_T: begin en_raw = 1'b1;            val_raw = gc;    end
      K_UNC_F: begin en_raw = 1'b1;            val_raw = gnc;   end
      K_OR_T:  begin en_raw = gc;              val_raw = 1'b1; mor_raw = 1'b1; end
      K_OR_F:  begin en_raw = gnc;             val_raw = 1'b1; mor_raw = 1'b1; end
      K_AND_T: begin en_raw = gnc;             mand_raw = 1'b1; end
      K_AND_F: begin en_raw = gc;              mand_raw = 1'b1; end
      K_CND_T: begin en_raw = guard;           val_raw = cond;  end
      K_CND_F: begin en_raw = guard;           val_raw = !cond; end
      K_DIS_T: begin en_raw = guard || cond;   val_raw = 1'b1; mor_raw = 1'b1; end
      K_DIS_F: begin en_raw = guard || !cond;  val_raw = 1'b1; mor_raw = 1'b1; end
      K_CON_T: begin en_raw = !guard || !cond; mand_raw = 1'b1; end
      K_CON_F: begin en_raw = !guard || cond;  mand_raw = 1'b1; end
      default: ;
    endcase
    // register 0 is hardwired; never target it
    wr.en    = en_raw && (idx != '0);
    wr.val   = wr.en && val_raw;
    wr.m_or  = wr.en && mor_raw;
    wr.m_and = wr.en && mand_raw;
  end
endmodule

// File: rtl/pdu_stage.sv
module pdu_stage #(
  parameter int SW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [SW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [SW-1:0] dn_data
);
  generate
    if (OUT_REG) begin : g_reg
      logic          vq;
      logic [SW-1:0] dq;

      assign up_ready = !vq || dn_ready;
      assign dn_valid = vq;
      assign dn_data  = dq;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vq <= 1'b0;
          dq <= '0;
        end else if (up_ready) begin
          vq <= up_valid;
          if (up_valid) dq <= up_data;
        end
      end

      // R12
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
      // R12
      accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_ready |=> dn_valid && (dn_data == $past(up_data)));
    end else begin : g_pass
      assign up_ready = dn_ready;
      assign dn_valid = up_valid;
      assign dn_data  = up_data;
    end
  endgenerate
endmodule

// File: rtl/pred_define_unit.sv
module pred_define_unit #(
  parameter int DW      = 32,
  parameter int IW      = 6,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] src0,
  input  logic [DW-1:0] src1,
  input  logic [3:0]    rel,
  input  logic          guard,
  input  logic [3:0]    kind0,
  input  logic [IW-1:0] dst0,
  input  logic [3:0]    kind1,
  input  logic [IW-1:0] dst1,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          wr0_en,
  output logic          wr0_val,
  output logic          wr0_mor,
  output logic          wr0_mand,
  output logic [IW-1:0] wr0_idx,
  output logic          wr1_en,
  output logic          wr1_val,
  output logic          wr1_mor,
  output logic          wr1_mand,
  output logic [IW-1:0] wr1_idx
);
  import pdu_pkg::*;

  localparam int ND = 2;
  localparam int LW = PWR_W + IW;
  localparam int SW = ND * LW;

  logic          cond;
  logic [3:0]    kind_a [ND];
  logic [IW-1:0] idx_a  [ND];
  pwr_t          wr_a   [ND];
  logic [SW-1:0] st_in, st_out;

  assign kind_a[0] = kind0;
  assign kind_a[1] = kind1;
  assign idx_a[0]  = dst0;
  assign idx_a[1]  = dst1;

  pdu_cmp #(.DW(DW)) u_cmp (
    .a(src0), .b(src1), .rel(rel), .cond(cond)
  );

  generate
    for (genvar d = 0; d < ND; d++) begin : g_dst
      pdu_deposit #(.IW(IW)) u_dep (
        .guard(guard), .cond(cond), .kind(kind_a[d]), .idx(idx_a[d]), .wr(wr_a[d])
      );
      assign st_in[d*LW +: LW] = {wr_a[d], idx_a[d]};
    end
  endgenerate

  pdu_stage #(.SW(SW), .OUT_REG(OUT_REG)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(st_in),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(st_out)
  );

  assign {wr0_en, wr0_val, wr0_mor, wr0_mand, wr0_idx} = st_out[LW-1:0];
  assign {wr1_en, wr1_val, wr1_mor, wr1_mand, wr1_idx} = st_out[SW-1:LW];

  // R11
  zero_idx_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wr0_en |-> wr0_idx != '0);
  // R11
  zero_idx_w1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wr1_en |-> wr1_idx != '0);
  // R10
  merge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(wr0_mor && wr0_mand) && !(wr1_mor && wr1_mand));
  // R3
  or_sets_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (wr0_mor || wr1_mor) |->
      (!wr0_mor || (wr0_en && wr0_val)) && (!wr1_mor || (wr1_en && wr1_val)));
  // R4
  and_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (wr0_mand || wr1_mand) |->
      (!wr0_mand || (wr0_en && !wr0_val)) && (!wr1_mand || (wr1_en && !wr1_val)));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !wr0_en && !wr1_en |-> $countones({wr0_val, wr0_mor, wr0_mand,
                                                   wr1_val, wr1_mor, wr1_mand}) == 0);
endmodule

// File: tb/sim_pred_define_unit.sv
`timescale 1ns/1ps
module sim_pred_define_unit;
  localparam int DW = 32;
  localparam int IW = 6;
  localparam int LW = 4 + IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0, in_ready;
  logic [DW-1:0] src0 = '0, src1 = '0;
  logic [3:0]    rel = '0, kind0 = '0, kind1 = '0;
  logic          guard = 1'b0;
  logic [IW-1:0] dst0 = '0, dst1 = '0;
  logic          out_valid, out_ready = 1'b0;
  logic          wr0_en, wr0_val, wr0_mor, wr0_mand;
  logic          wr1_en, wr1_val, wr1_mor, wr1_mand;
  logic [IW-1:0] wr0_idx, wr1_idx;

  pred_define_unit #(.DW(DW), .IW(IW), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src0(src0), .src1(src1), .rel(rel), .guard(guard),
    .kind0(kind0), .dst0(dst0), .kind1(kind1), .dst1(dst1),
    .out_valid(out_valid), .out_ready(out_ready),
    .wr0_en(wr0_en), .wr0_val(wr0_val), .wr0_mor(wr0_mor), .wr0_mand(wr0_mand), .wr0_idx(wr0_idx),
    .wr1_en(wr1_en), .wr1_val(wr1_val), .wr1_mor(wr1_mor), .wr1_mand(wr1_mand), .wr1_idx(wr1_idx)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  bit stall_mode = 1'b1;

  logic [2*LW-1:0] exp_q[$];
  string           tag_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic ref_cond(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                    input logic [3:0] r);
    case (r)
      4'd0: return a == b;
      4'd1: return a != b;
      4'd2: return $signed(a) <  $signed(b);
      4'd3: return $signed(a) <= $signed(b);
      4'd4: return $signed(a) >  $signed(b);
      4'd5: return $signed(a) >= $signed(b);
      4'd6: return a <  b;
      4'd7: return a <= b;
      4'd8: return a >  b;
      default: return 1'b0;
    endcase
  endfunction

  // action: 0 leave, 1 write zero, 2 write one
  function automatic logic [LW-1:0] ref_dst(input logic g, input logic c,
                                            input logic [3:0] k, input logic [IW-1:0] ix);
    int act;
    logic en, mo, ma;
    case (k)
      4'd0:  act = (g && c)  ? 2 : 1;
      4'd1:  act = (g && !c) ? 2 : 1;
      4'd2:  act = (g && c)  ? 2 : 0;
      4'd3:  act = (g && !c) ? 2 : 0;
      4'd4:  act = (g && !c) ? 1 : 0;
      4'd5:  act = (g && c)  ? 1 : 0;
      4'd6:  act = g ? (c ? 2 : 1) : 0;
      4'd7:  act = g ? (c ? 1 : 2) : 0;
      4'd8:  act = (g || c)   ? 2 : 0;
      4'd9:  act = (g || !c)  ? 2 : 0;
      4'd10: act = (!g || !c) ? 1 : 0;
      4'd11: act = (!g || c)  ? 1 : 0;
      default: act = 0;
    endcase
    if (ix == '0) act = 0;
    en = (act != 0);
    mo = en && (k == 4'd2 || k == 4'd3 || k == 4'd8 || k == 4'd9);
    ma = en && (k == 4'd4 || k == 4'd5 || k == 4'd10 || k == 4'd11);
    return {en, act == 2, mo, ma, ix};
  endfunction

  function automatic string kind_req(input logic [3:0] k);
    if (k < 2)  return "R2";
    if (k < 4)  return "R3";
    if (k < 6)  return "R4";
    if (k < 8)  return "R5";
    if (k < 10) return "R6";
    if (k < 12) return "R7";
    return "R8";
  endfunction

  task automatic send(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [3:0] r,
                      input logic g, input logic [3:0] k0, input logic [IW-1:0] i0,
                      input logic [3:0] k1, input logic [IW-1:0] i1, input string req);
    logic c;
    c = ref_cond(a, b, r);
    @(negedge clk);
    in_valid = 1'b1; src0 = a; src1 = b; rel = r; guard = g;
    kind0 = k0; dst0 = i0; kind1 = k1; dst1 = i1;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    exp_q.push_back({ref_dst(g, c, k1, i1), ref_dst(g, c, k0, i0)});
    tag_q.push_back(req);
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
  endtask

  // monitor: drive ready, compare against scoreboard
  initial begin : monitor
    logic [2*LW-1:0] prev, got, exp;
    bit prev_stall;
    string req;
    prev_stall = 1'b0;
    prev = '0;
    forever begin
      @(negedge clk);
      out_ready = stall_mode ? ($urandom_range(0, 9) < 6) : 1'b1;
      #1;
      got = {wr1_en, wr1_val, wr1_mor, wr1_mand, wr1_idx,
             wr0_en, wr0_val, wr0_mor, wr0_mand, wr0_idx};
      if (rst_n && prev_stall)
        check(out_valid && got == prev, "R12", "stalled output held",
              {11'd0, out_valid, got}, {11'd1, prev});
      prev_stall = rst_n && out_valid && !out_ready;
      prev = got;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R12", "result with nothing accepted", {12'd0, got}, 32'd0);
        end else begin
          exp = exp_q.pop_front();
          req = tag_q.pop_front();
          check(got[LW-1:0] == exp[LW-1:0], req, "destination 0 write",
                {22'd0, got[LW-1:0]}, {22'd0, exp[LW-1:0]});
          check(got[2*LW-1:LW] == exp[2*LW-1:LW], "R9", "destination 1 write",
                {22'd0, got[2*LW-1:LW]}, {22'd0, exp[2*LW-1:LW]});
          check({got[LW+IW+1:LW+IW], got[IW+1:IW]} == {exp[LW+IW+1:LW+IW], exp[IW+1:IW]},
                "R10", "merge flags",
                {28'd0, got[LW+IW+1:LW+IW], got[IW+1:IW]},
                {28'd0, exp[LW+IW+1:LW+IW], exp[IW+1:IW]});
        end
      end
    end
  end

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    check(1'b0, "R12", "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin : driver
    logic [DW-1:0] pa [5];
    logic [DW-1:0] pb [5];
    pa[0] = 32'd5;          pb[0] = 32'd5;
    pa[1] = 32'hFFFF_FFFD;  pb[1] = 32'd2;
    pa[2] = 32'd2;          pb[2] = 32'hFFFF_FFFD;
    pa[3] = 32'd7;          pb[3] = 32'd9;
    pa[4] = 32'hFFFF_FFF0;  pb[4] = 32'd1;

    repeat (3) @(negedge clk);
    #1;
    // R12: reset state
    check(out_valid == 1'b0, "R12", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12", "empty after reset",
          {30'd0, out_valid, in_ready}, 32'd1);

    // R1: relation sweep, UT on dst0 exposes C directly
    for (int p = 0; p < 5; p++)
      for (int r = 0; r < 16; r++)
        send(pa[p], pb[p], r[3:0], 1'b1, 4'd0, 6'd1, 4'd7, 6'd2, "R1");

    // R2..R8, R9, R10: every kind under every guard/condition pairing
    for (int k = 0; k < 16; k++)
      for (int g = 0; g < 2; g++)
        for (int c = 0; c < 2; c++)
          send(32'd4, c ? 32'd4 : 32'd6, 4'd0, g[0], k[3:0], 6'd3,
               4'(15 - k), 6'd4, kind_req(k[3:0]));

    // R11: index 0 suppresses every kind that would write
    for (int k = 0; k < 12; k++)
      send(32'd1, 32'd1, 4'd0, 1'b1, k[3:0], 6'd0, k[3:0], 6'd0, "R11");
    send(32'd1, 32'd2, 4'd0, 1'b0, 4'd0, 6'd0, 4'd10, 6'd0, "R11");

    // R9: random mixes, independent kinds and indices
    for (int n = 0; n < 300; n++)
      send($urandom, ($urandom_range(0, 3) == 0) ? 32'd77 : $urandom, 4'($urandom_range(0, 15)),
           1'($urandom), 4'($urandom_range(0, 15)), 6'($urandom),
           4'($urandom_range(0, 15)), 6'($urandom), "R9");

    // drain
    stall_mode = 1'b0;
    for (int w = 0; w < 100 && exp_q.size() != 0; w++) @(negedge clk);
    check(exp_q.size() == 0, "R12", "all results delivered", exp_q.size(), 32'd0);
    repeat (2) @(negedge clk);
    report();
  end
endmodule